// File: doc/BRIEF.md
# Per-CPU Interrupt Level Encoder

This block keeps the 32-bit pending word of a single processor and turns it into fifteen separate interrupt level lines, levels 1 through 15. Four inputs feed it. Software raises and drops soft interrupts through a small word-addressed register port. A per-processor timer line and a broadcast level-15 line are captured into dedicated pending bits. The router supplies a ready-made hard level vector and a status vector.

The status vector is only for software to read. Soft interrupts occupy the upper half of the pending word and reach the level lines shifted down by sixteen. The timer and level-15 bits skip the normal per-source masking and are blocked only by the router's global disable flag. Soft interrupts are never masked.

The level lines are registered, so every line changes only on a clock edge. Each edge uses the pending state that the same edge loads.

Top module: `irl_lvl_encoder`

## Requirements
- R1: Only accesses with all four byte enables set are accepted. An accepted read at word offset 0 returns the pending word in the same cycle. Every other read (offsets 1 and up, partial byte enables, or no access) returns zero.
- R2: An accepted write at offset 2 sets the pending bits where the write data has ones, limited to mask 0xFFFE0000. Bits 16..0 of the data are ignored.
- R3: An accepted write at offset 1 clears the soft pending bits where the write data has ones, limited to mask 0xFFFE0000. Bit 15 of the same data acknowledges the level-15 bit (see R6).
- R4: Pending bit n (31..17) drives level line n-16. Soft bits are never masked, including while global disable is high.
- R5: Pending bit 14 follows the timer input with one clock of delay. It drives level line 14 only while global disable is low.
- R6: Pending bit 15 follows the broadcast level-15 input with one clock of delay. A clear write with bit 15 set drops it, and it stays low until the input has gone low and high again. It drives level line 15 only while global disable is low.
- R7: Pending bits 13..0 hold the router status vector, sampled on each edge at which this processor is the target, and hold zero otherwise. Pending bit 16 always reads zero.
- R8: Each level line i (1..15) is the OR of hard level input bit i and the soft, timer and level-15 contributions. Level line 0 is always low.
- R9: All level lines and pending bits are registered. An input change shows on the outputs after the next rising clock edge and not before.
- R10: While reset is asserted, the pending word reads zero and all level lines are low.
- R11: Writes with partial byte enables, and writes to any offset other than 1 or 2, leave the pending word and the level lines unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Register access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_off | input | 4 | Word offset |
| acc_be | input | 4 | Byte enables; all must be set |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, combinational |
| timer_in | input | 1 | Per-processor timer line |
| bcast15_in | input | 1 | Broadcast level-15 line |
| is_target | input | 1 | This processor is the router's target |
| hard_status | input | 14 | Router status vector for pending bits 13..0 |
| hard_level | input | 15 | Router hard levels 15..1 |
| global_dis | input | 1 | Router global disable flag |
| irl_o | output | 16 | Level lines; bit 0 is always low |

## Verification
The bench builds the block with its default parameters: a 4-bit word offset, so the unmapped offsets 3 through 15 can all be reached, and the fixed 32-bit word layout. These values make it possible to probe every soft bit's shift to its level line at once, and to watch the timer and level-15 bits interact with global disable. They also cover the acknowledge-and-rearm sequence of the level-15 bit and the one-edge output latency.

// File: rtl/irl_enc_pkg.sv
package irl_enc_pkg;
    localparam int DW       = 32;
    localparam int BE_W     = DW / 8;
    localparam int LVLS     = 16;
    localparam int SOFT_SH  = 16;
    localparam int TMR_BIT  = 14;
    localparam int L15_BIT  = 15;
    localparam int HARD_W   = 14;
    localparam logic [DW-1:0] SOFT_MASK = 32'hFFFE_0000;
    localparam int OFF_PEND = 0;
    localparam int OFF_CLR  = 1;
    localparam int OFF_SET  = 2;

    typedef struct packed {
        logic              tmr;
        logic              l15;
        logic              ack;
        logic [HARD_W-1:0] hard;
    } line_st_t;
endpackage

// File: rtl/irl_soft_bank.sv
module irl_soft_bank
    import irl_enc_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en,
    input  logic          clr_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] soft_d,
    output logic [DW-1:0] soft_q
);
    logic [DW-1:0] set_bits;
    logic [DW-1:0] clr_bits;

    always_comb begin
        set_bits = set_en ? (wdata & SOFT_MASK) : '0;
        clr_bits = clr_en ? (wdata & SOFT_MASK) : '0;
        soft_d   = (soft_q | set_bits) & ~clr_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) soft_q <= '0;
        else        soft_q <= soft_d;
    end
endmodule

// File: rtl/irl_line_capture.sv
module irl_line_capture
    import irl_enc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              timer_in,
    input  logic              bcast15_in,
    input  logic              ack15,
    input  logic              is_target,
    input  logic [HARD_W-1:0] hard_status,
    output line_st_t          line_d,
    output line_st_t          line_q
);
    always_comb begin
        line_d.tmr  = timer_in;
        line_d.ack  = bcast15_in & (line_q.ack | ack15);
        line_d.l15  = bcast15_in & ~line_d.ack;
        line_d.hard = is_target ? hard_status : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_q <= '0;
        else        line_q <= line_d;
    end
endmodule

// File: rtl/irl_level_merge.sv
module irl_level_merge
    import irl_enc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DW-1:0]   soft_nxt,
    input  logic            tmr_nxt,
    input  logic            l15_nxt,
    input  logic [LVLS-1:1] hard_level,
    input  logic            global_dis,
    output logic [LVLS-1:0] irl_q
);
    logic [LVLS-1:0] irl_d;

    assign irl_d[0] = 1'b0;

    genvar lv;
    generate
        for (lv = 1; lv < LVLS; lv++) begin : g_lvl
            logic side;
            if (lv == TMR_BIT) begin : g_tmr
                assign side = tmr_nxt & ~global_dis;
            end else if (lv == L15_BIT) begin : g_l15
                assign side = l15_nxt & ~global_dis;
            end else begin : g_none
                assign side = 1'b0;
            end
            assign irl_d[lv] = hard_level[lv] | soft_nxt[lv + SOFT_SH] | side;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irl_q <= '0;
        else        irl_q <= irl_d;
    end
endmodule

// File: rtl/irl_lvl_encoder.sv
module irl_lvl_encoder
    import irl_enc_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_en,
    input  logic               acc_wr,
    input  logic [ADDR_W-1:0]  acc_off,
    input  logic [BE_W-1:0]    acc_be,
    input  logic [DW-1:0]      acc_wdata,
    output logic [DW-1:0]      acc_rdata,
    input  logic               timer_in,
    input  logic               bcast15_in,
    input  logic               is_target,
    input  logic [HARD_W-1:0]  hard_status,
    input  logic [LVLS-1:1]    hard_level,
    input  logic               global_dis,
    output logic [LVLS-1:0]    irl_o
);
    logic          acc_ok;
    logic          wr_set;
    logic          wr_clr;
    logic [DW-1:0] soft_d;
    logic [DW-1:0] soft_q;
    line_st_t      line_d;
    line_st_t      line_q;
    logic [DW-1:0] pend_q;

    always_comb begin
        acc_ok = acc_en & (&acc_be);
        wr_set = acc_ok & acc_wr & (acc_off == ADDR_W'(OFF_SET));
        wr_clr = acc_ok & acc_wr & (acc_off == ADDR_W'(OFF_CLR));
        pend_q = soft_q;
        pend_q[L15_BIT]    = line_q.l15;
        pend_q[TMR_BIT]    = line_q.tmr;
        pend_q[HARD_W-1:0] = line_q.hard;
        acc_rdata = (acc_ok & ~acc_wr & (acc_off == ADDR_W'(OFF_PEND))) ? pend_q : '0;
    end

    irl_soft_bank u_soft (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (wr_set),
        .clr_en (wr_clr),
        .wdata  (acc_wdata),
        .soft_d (soft_d),
        .soft_q (soft_q)
    );

    irl_line_capture u_line (
        .clk         (clk),
        .rst_n       (rst_n),
        .timer_in    (timer_in),
        .bcast15_in  (bcast15_in),
        .ack15       (wr_clr & acc_wdata[L15_BIT]),
        .is_target   (is_target),
        .hard_status (hard_status),
        .line_d      (line_d),
        .line_q      (line_q)
    );

    irl_level_merge u_merge (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_nxt   (soft_d),
        .tmr_nxt    (line_d.tmr),
        .l15_nxt    (line_d.l15),
        .hard_level (hard_level),
        .global_dis (global_dis),
        .irl_q      (irl_o)
    );
endmodule

// File: rtl/irl_lvl_encoder_chk.sv
module irl_lvl_encoder_chk
    import irl_enc_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_en,
    input logic              acc_wr,
    input logic [ADDR_W-1:0] acc_off,
    input logic [BE_W-1:0]   acc_be,
    input logic [DW-1:0]     acc_wdata,
    input logic [DW-1:0]     acc_rdata,
    input logic              timer_in,
    input logic              is_target,
    input logic [DW-1:0]     pend,
    input logic [LVLS-1:0]   irl_o
);
    // R8: level 0 never driven
    a_r8_level0_low: assert property (@(posedge clk) disable iff (!rst_n)
        irl_o[0] == 1'b0);

    // R4: every pending soft bit appears on its level line
    a_r4_soft_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        (irl_o[LVLS-1:1] & pend[DW-1:SOFT_SH+1]) == pend[DW-1:SOFT_SH+1]);

    // R5: timer bit follows its line one edge later
    a_r5_timer_follow: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> pend[TMR_BIT] == $past(timer_in));

    // R7: status bits are zero when not targeted
    a_r7_not_target_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !is_target |=> pend[HARD_W-1:0] == '0);

    // R1: reads off offset 0 return zero
    a_r1_other_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_wr && acc_off != '0) |-> acc_rdata == '0);

    // R2: set write leaves the masked bits set
    a_r2_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_wr && (&acc_be) && acc_off == ADDR_W'(OFF_SET))
        |=> (pend & $past(acc_wdata) & SOFT_MASK) == ($past(acc_wdata) & SOFT_MASK));

    // R7: bit 16 is never pending
    a_r7_bit16_zero: assert property (@(posedge clk) disable iff (!rst_n)
        pend[SOFT_SH] == 1'b0);
endmodule

bind irl_lvl_encoder irl_lvl_encoder_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_en    (acc_en),
    .acc_wr    (acc_wr),
    .acc_off   (acc_off),
    .acc_be    (acc_be),
    .acc_wdata (acc_wdata),
    .acc_rdata (acc_rdata),
    .timer_in  (timer_in),
    .is_target (is_target),
    .pend      (pend_q),
    .irl_o     (irl_o)
);

// File: tb/irl_lvl_encoder_tb.sv
`timescale 1ns/1ps
module irl_lvl_encoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_en = 1'b0;
    logic        acc_wr = 1'b0;
    logic [3:0]  acc_off = '0;
    logic [3:0]  acc_be = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic        timer_in = 1'b0;
    logic        bcast15_in = 1'b0;
    logic        is_target = 1'b0;
    logic [13:0] hard_status = '0;
    logic [15:1] hard_level = '0;
    logic        global_dis = 1'b0;
    logic [15:0] irl_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    int          kind_q[$];
    logic [31:0] exp_q[$];
    string       tag_q[$];
    event        smp_ev;

    always #5 clk = ~clk;

    irl_lvl_encoder u_dut (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
        .acc_off(acc_off), .acc_be(acc_be), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .timer_in(timer_in), .bcast15_in(bcast15_in),
        .is_target(is_target), .hard_status(hard_status),
        .hard_level(hard_level), .global_dis(global_dis), .irl_o(irl_o)
    );

    // monitor: pops expected items and compares with the live outputs
    always begin
        @(smp_ev);
        while (exp_q.size() > 0) begin
            automatic int          k   = kind_q.pop_front();
            automatic logic [31:0] e   = exp_q.pop_front();
            automatic string       t   = tag_q.pop_front();
            automatic logic [31:0] act = (k == 0) ? acc_rdata : {16'h0, irl_o};
            n_run++;
            if (act !== e) begin
                n_fail++;
                $display("FAIL %s: actual %08h expected %08h", t, act, e);
            end
        end
    end

    task automatic push_chk(input int k, input logic [31:0] e, input string t);
        kind_q.push_back(k);
        exp_q.push_back(e);
        tag_q.push_back(t);
        ->smp_ev;
        #1;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk_irl(input logic [15:0] e, input string t);
        push_chk(1, {16'h0, e}, t);
    endtask

    task automatic rd(input logic [3:0] off, input logic [3:0] be,
                      input logic [31:0] e, input string t);
        @(negedge clk);
        acc_en = 1'b1; acc_wr = 1'b0; acc_off = off; acc_be = be;
        #2;
        push_chk(0, e, t);
        acc_en = 1'b0;
    endtask

    task automatic wr(input logic [3:0] off, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        acc_en = 1'b1; acc_wr = 1'b1; acc_off = off; acc_be = be; acc_wdata = d;
        @(negedge clk);
        acc_en = 1'b0; acc_wr = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        tick();
        // R10 reset state
        rd(4'd0, 4'hF, 32'h0, "R10 pending after reset");
        chk_irl(16'h0, "R10 levels after reset");

        // R2 set, masked; R4 shift
        wr(4'd2, 4'hF, 32'hFFFF_FFFF);
        rd(4'd0, 4'hF, 32'hFFFE_0000, "R2 set masked");
        chk_irl(16'hFFFE, "R4 soft to levels");
        wr(4'd2, 4'hF, 32'h0001_FFFF);
        rd(4'd0, 4'hF, 32'hFFFE_0000, "R2 low bits ignored");

        // R3 clear
        wr(4'd1, 4'hF, 32'h000A_0000);
        rd(4'd0, 4'hF, 32'hFFF4_0000, "R3 clear selected");
        chk_irl(16'hFFF4, "R3 levels after clear");

        // R4 never masked
        global_dis = 1'b1; tick();
        chk_irl(16'hFFF4, "R4 soft under disable");
        global_dis = 1'b0;
        wr(4'd1, 4'hF, 32'hFFFF_FFFF);
        rd(4'd0, 4'hF, 32'h0, "R3 clear all");

        // R5 timer
        timer_in = 1'b1; tick();
        rd(4'd0, 4'hF, 32'h0000_4000, "R5 timer pending");
        chk_irl(16'h4000, "R5 timer level");
        global_dis = 1'b1; tick();
        chk_irl(16'h0000, "R5 timer masked by disable");
        rd(4'd0, 4'hF, 32'h0000_4000, "R5 pending kept under disable");
        timer_in = 1'b0; global_dis = 1'b0; tick();
        rd(4'd0, 4'hF, 32'h0, "R5 timer follows low");

        // R6 level-15
        bcast15_in = 1'b1; tick();
        rd(4'd0, 4'hF, 32'h0000_8000, "R6 level15 pending");
        chk_irl(16'h8000, "R6 level15 line");
        wr(4'd1, 4'hF, 32'h0000_8000);
        rd(4'd0, 4'hF, 32'h0, "R6 acknowledged");
        chk_irl(16'h0000, "R6 line dropped on ack");
        tick();
        rd(4'd0, 4'hF, 32'h0, "R6 stays acked while high");
        bcast15_in = 1'b0; tick();
        bcast15_in = 1'b1; tick();
        chk_irl(16'h8000, "R6 rearmed");
        global_dis = 1'b1; tick();
        chk_irl(16'h0000, "R6 masked by disable");
        global_dis = 1'b0; bcast15_in = 1'b0; tick();

        // R7 status
        hard_status = 14'h2AAA; is_target = 1'b0; tick();
        rd(4'd0, 4'hF, 32'h0, "R7 not target");
        is_target = 1'b1; tick();
        rd(4'd0, 4'hF, 32'h0000_2AAA, "R7 target status");
        chk_irl(16'h0000, "R7 status drives no level");
        hard_status = 14'h3FFF; tick();
        rd(4'd0, 4'hF, 32'h0000_3FFF, "R7 status all ones");

        // R8 merge with hard levels
        hard_level = 15'h0005; tick();
        chk_irl(16'h000A, "R8 hard levels");
        wr(4'd2, 4'hF, 32'h0004_0000);
        chk_irl(16'h000E, "R8 hard OR soft");
        rd(4'd0, 4'hF, 32'h0004_3FFF, "R8 pending combined");

        // R11 ignored writes, R1 other reads
        wr(4'd2, 4'h7, 32'hFFFE_0000);
        wr(4'd5, 4'hF, 32'hFFFE_0000);
        wr(4'd1, 4'hE, 32'hFFFF_FFFF);
        rd(4'd0, 4'hF, 32'h0004_3FFF, "R11 writes ignored");
        chk_irl(16'h000E, "R11 levels unchanged");
        rd(4'd1, 4'hF, 32'h0, "R1 offset 1 reads zero");
        rd(4'd7, 4'hF, 32'h0, "R1 unmapped reads zero");
        rd(4'd0, 4'h3, 32'h0, "R1 partial read zero");

        // R9 registered outputs
        hard_level = '0;
        wr(4'd1, 4'hF, 32'h0004_0000);
        chk_irl(16'h0000, "R9 baseline");
        timer_in = 1'b1;
        chk_irl(16'h0000, "R9 no change before edge");
        tick();
        chk_irl(16'h4000, "R9 change after edge");

        // R10 mid-run reset
        rst_n = 1'b0; #1;
        chk_irl(16'h0000, "R10 levels in reset");
        rd(4'd0, 4'hF, 32'h0, "R10 pending in reset");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule